// File: doc/BRIEF.md
# Warp Global Memory Request Splitter

This block takes one warp-wide global load or store, as a set of per-lane byte addresses with an active mask, and turns it into a stream of memory transactions. The access size is the same for every lane of the request: 4, 8 or 16 bytes. The size decides how the warp is cut into lane groups. Inside each group, active lanes whose addresses fall in the same aligned segment are merged into a single transaction.

A mode bit chooses the segment size. With the bit set, the access is cached in both cache levels and segments are 128 bytes. With the bit clear, the access is cached only in the second-level cache and segments are 32 bytes. Transactions leave one per cycle on a valid/ready port. Each one carries the segment base, a mask of the bytes touched and a mask of the lanes it serves.

A request whose active addresses are not naturally aligned is refused. The block raises an error flag and emits nothing for it. The block takes no new request until the downstream side has accepted every transaction of the current one.

Top module: `warp_seg_splitter`

## Requirements
- R1: The access size code sets the lane groups. Code 0 (4 bytes) makes all 32 lanes one group. Code 1 (8 bytes) makes two groups, lanes 0..15 and lanes 16..31. Code 2 (16 bytes) makes four groups of 8 consecutive lanes. Lanes in different groups never share a transaction, even when their addresses match.
- R2: With req_wide = 1, every transaction base is aligned to 128 bytes. txn_bytes bit k stands for byte base+k, over all 128 bits.
- R3: With req_wide = 0, every transaction base is aligned to 32 bytes, and only txn_bytes bits 31..0 can be set.
- R4: All active lanes of one group that fall in the same segment are served by exactly one transaction. That transaction's byte mask is the union of the bytes those lanes touch, and identical or overlapping addresses fold together.
- R5: Groups are emitted in ascending order. Within a group, segments are emitted in ascending order of the lowest lane that touches each one.
- R6: Inactive lanes produce no transactions and appear in no lane mask. A group with no active lane is skipped, and a request with no active lane produces no transaction at all.
- R7: For a load (req_store = 0), txn_lanes holds every lane the transaction serves. For a store (req_store = 1), it holds only the lowest lane of each distinct address within the transaction, which is the single writer of that word.
- R8: A request with size code 3, or with any active lane whose address is not a multiple of its access size, produces no transaction. err_misalign is then high for exactly the one cycle after the request is accepted.
- R9: req_ready is high after reset and whenever the block is idle. It is low from the cycle after a request with at least one transaction is accepted until that request's last transaction has been accepted.
- R10: While txn_valid is high and txn_ready is low, txn_valid stays high and txn_base, txn_bytes and txn_lanes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block can accept a warp request |
| req_addr | input | LANES*AW | Per-lane byte addresses; lane i in bits i*AW +: AW |
| req_active | input | LANES | Active lane mask |
| req_size | input | 2 | Access size code: 0 = 4 B, 1 = 8 B, 2 = 16 B, 3 = invalid |
| req_wide | input | 1 | 1: 128-byte segments (both cache levels); 0: 32-byte segments |
| req_store | input | 1 | 1: store, 0: load |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_base | output | AW | Segment base address |
| txn_bytes | output | LINE_B | Bytes touched, bit k = byte base+k |
| txn_lanes | output | LANES | Lanes served (load) or writing lanes (store) |
| err_misalign | output | 1 | One-cycle flag for a refused request |

## Verification
The directed cases target grouping: all lanes on one address at 8-byte and 16-byte size must still produce two and four transactions. A design that merged across groups would emit fewer. Reversed lane addresses check the emission order, so a design that sorted by address or by segment would return the segments in the wrong sequence. Stores with every lane on one word check that only the lowest active lane writes; a design that kept the highest lane or all of them would show the wrong lane mask. Misaligned requests, empty groups and long downstream stalls check that nothing leaks out on refusal, that empty groups cost no transaction, and that a held transaction does not change or advance.

// File: rtl/wss_pkg.sv
package wss_pkg;

   // access size codes carried on req_size
   typedef enum logic [1:0] {
      ACC_W4  = 2'd0,
      ACC_W8  = 2'd1,
      ACC_W16 = 2'd2,
      ACC_BAD = 2'd3
   } acc_size_e;

endpackage

// File: rtl/wss_lowest.sv
// Lowest set bit finder: returns index of the lowest set bit of vec.
module wss_lowest #(
   parameter int N = 32
) (
   input  logic [N-1:0]         vec,
   output logic [$clog2(N)-1:0] idx,
   output logic                 any
);
   localparam int IW = $clog2(N);

   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/wss_gather.sv
// Given the pending lanes and the leader lane, find every lane that shares
// the leader's group and segment, and build the byte and lane masks.
module wss_gather #(
   parameter int LANES  = 32,
   parameter int AW     = 32,
   parameter int LINE_B = 128,
   parameter int SECT_B = 32
) (
   input  logic [LANES*AW-1:0]      addr_flat,
   input  logic [LANES-1:0]         pend,
   input  logic [$clog2(LANES)-1:0] leader,
   input  logic [1:0]               size,
   input  logic                     wide,
   input  logic                     store,
   output logic [AW-1:0]            base,
   output logic [LANES-1:0]         served,
   output logic [LANES-1:0]         lanes,
   output logic [LINE_B-1:0]        bytes
);
   import wss_pkg::*;

   localparam int LW = $clog2(LANES);
   localparam int OW = $clog2(LINE_B);

   logic [AW-1:0]     a [LANES];
   logic [AW-1:0]     seg_mask;
   logic [OW-1:0]     off_mask;
   logic [LINE_B-1:0] unit;
   int                gshift;

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign a[g] = addr_flat[g*AW +: AW];
   end

   always_comb begin
      seg_mask = wide ? ~AW'(LINE_B - 1) : ~AW'(SECT_B - 1);
      off_mask = wide ? OW'(LINE_B - 1) : OW'(SECT_B - 1);
      unique case (acc_size_e'(size))
         ACC_W4:  begin unit = LINE_B'(4'hF);     gshift = LW;     end
         ACC_W8:  begin unit = LINE_B'(8'hFF);    gshift = LW - 1; end
         default: begin unit = LINE_B'(16'hFFFF); gshift = LW - 2; end
      endcase
   end

   assign base = a[leader] & seg_mask;

   always_comb begin
      logic dup;
      served = '0;
      lanes  = '0;
      bytes  = '0;
      for (int i = 0; i < LANES; i++) begin
         if (pend[i] && ((i >> gshift) == (int'(leader) >> gshift))
             && ((a[i] & seg_mask) == base))
            served[i] = 1'b1;
      end
      for (int i = 0; i < LANES; i++) begin
         dup = 1'b0;
         for (int j = 0; j < i; j++) begin
            // same segment, same size, natural alignment: equal offset = same word
            if (served[j] && (a[j][OW-1:0] == a[i][OW-1:0])) dup = 1'b1;
         end
         if (served[i]) begin
            bytes    = bytes | (unit << (a[i][OW-1:0] & off_mask));
            lanes[i] = !store || !dup;
         end
      end
   end
endmodule

// File: rtl/warp_seg_splitter.sv
module warp_seg_splitter #(
   parameter int LANES  = 32,
   parameter int AW     = 32,
   parameter int LINE_B = 128,
   parameter int SECT_B = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [LANES*AW-1:0] req_addr,
   input  logic [LANES-1:0]    req_active,
   input  logic [1:0]          req_size,
   input  logic                req_wide,
   input  logic                req_store,
   output logic                txn_valid,
   input  logic                txn_ready,
   output logic [AW-1:0]       txn_base,
   output logic [LINE_B-1:0]   txn_bytes,
   output logic [LANES-1:0]    txn_lanes,
   output logic                err_misalign
);
   import wss_pkg::*;

   localparam int LW = $clog2(LANES);

   // elaboration-time parameter checks
   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 4");
   end
   if (SECT_B < 16 || (SECT_B & (SECT_B - 1)) != 0) begin : g_bad_sect
      $error("SECT_B must be a power of two of at least 16");
   end
   if (LINE_B < SECT_B || (LINE_B & (LINE_B - 1)) != 0) begin : g_bad_line
      $error("LINE_B must be a power of two not below SECT_B");
   end
   if (AW <= $clog2(LINE_B)) begin : g_bad_aw
      $error("AW too narrow for LINE_B");
   end

   logic [LANES*AW-1:0] addr_q;
   logic [LANES-1:0]    pend_q;
   logic [1:0]          size_q;
   logic                wide_q;
   logic                store_q;

   logic [LW-1:0]       leader;
   logic [LANES-1:0]    served;
   logic                refuse;
   logic                accept;
   logic                fire;

   // natural alignment check on the incoming request
   always_comb begin
      logic [3:0] lo;
      refuse = (acc_size_e'(req_size) == ACC_BAD);
      for (int i = 0; i < LANES; i++) begin
         lo = req_addr[i*AW +: 4];
         if (req_active[i]) begin
            unique case (acc_size_e'(req_size))
               ACC_W4:  if (lo[1:0] != 2'b0) refuse = 1'b1;
               ACC_W8:  if (lo[2:0] != 3'b0) refuse = 1'b1;
               ACC_W16: if (lo[3:0] != 4'b0) refuse = 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign req_ready = ~|pend_q;
   assign accept    = req_valid && req_ready;
   assign fire      = txn_valid && txn_ready;

   wss_lowest #(.N(LANES)) u_pick (
      .vec (pend_q),
      .idx (leader),
      .any (txn_valid)
   );

   wss_gather #(
      .LANES (LANES),
      .AW    (AW),
      .LINE_B(LINE_B),
      .SECT_B(SECT_B)
   ) u_gather (
      .addr_flat(addr_q),
      .pend     (pend_q),
      .leader   (leader),
      .size     (size_q),
      .wide     (wide_q),
      .store    (store_q),
      .base     (txn_base),
      .served   (served),
      .lanes    (txn_lanes),
      .bytes    (txn_bytes)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q       <= '0;
         pend_q       <= '0;
         size_q       <= '0;
         wide_q       <= 1'b0;
         store_q      <= 1'b0;
         err_misalign <= 1'b0;
      end else begin
         err_misalign <= accept && refuse;
         if (accept && !refuse) begin
            addr_q  <= req_addr;
            pend_q  <= req_active;
            size_q  <= req_size;
            wide_q  <= req_wide;
            store_q <= req_store;
         end else if (fire) begin
            pend_q <= pend_q & ~served;
         end
      end
   end
endmodule

// File: rtl/wss_chk.sv
module wss_chk #(
   parameter int LANES  = 32,
   parameter int AW     = 32,
   parameter int LINE_B = 128,
   parameter int SECT_B = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              txn_valid,
   input logic              txn_ready,
   input logic [AW-1:0]     txn_base,
   input logic [LINE_B-1:0] txn_bytes,
   input logic [LANES-1:0]  txn_lanes,
   input logic              err_misalign
);
   a_r9_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> !req_ready);

   a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base)
                                     && $stable(txn_bytes) && $stable(txn_lanes)));

   a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_base & AW'(SECT_B - 1)) == '0));

   a_r4_txn_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((|txn_lanes) && (|txn_bytes)));

   a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      err_misalign |-> !txn_valid);

   a_r8_err_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      err_misalign |-> $past(req_valid && req_ready));
endmodule

bind warp_seg_splitter wss_chk #(
   .LANES (LANES),
   .AW    (AW),
   .LINE_B(LINE_B),
   .SECT_B(SECT_B)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .txn_valid   (txn_valid),
   .txn_ready   (txn_ready),
   .txn_base    (txn_base),
   .txn_bytes   (txn_bytes),
   .txn_lanes   (txn_lanes),
   .err_misalign(err_misalign)
);

// File: tb/test_warp_seg_splitter.sv
module test_warp_seg_splitter;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1023:0] req_addr = '0;
   logic [31:0]   req_active = '0;
   logic [1:0]    req_size = '0;
   logic          req_wide = 1'b0;
   logic          req_store = 1'b0;
   logic          txn_valid;
   logic          txn_ready = 1'b0;
   logic [31:0]   txn_base;
   logic [127:0]  txn_bytes;
   logic [31:0]   txn_lanes;
   logic          err_misalign;

   int total = 0;
   int bad   = 0;

   // stimulus of the current warp
   logic [31:0] a [32];
   logic [31:0] act;
   int          sz;
   bit          wide, st;

   // expected transactions
   logic [31:0]  e_base  [32];
   logic [127:0] e_bytes [32];
   logic [31:0]  e_lanes [32];
   logic [31:0]  e_srv   [32];
   int           e_n;
   bit           e_err;

   always #10 clk = ~clk;

   warp_seg_splitter i_warp_seg_splitter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_active(req_active), .req_size(req_size),
      .req_wide(req_wide), .req_store(req_store), .txn_valid(txn_valid),
      .txn_ready(txn_ready), .txn_base(txn_base), .txn_bytes(txn_bytes),
      .txn_lanes(txn_lanes), .err_misalign(err_misalign)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act_v, input logic [127:0] exp_v);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act_v, exp_v);
      end
   endtask

   // reference: walk groups, then lanes, listing segments by first touch
   task automatic model();
      int nb, segsz, gl, k0, found;
      logic [31:0] sb;
      bit winner;
      e_n = 0;
      nb = 4 << sz;
      e_err = (sz == 3);
      for (int l = 0; l < 32; l++)
         if (act[l] && sz < 3 && (a[l] % nb) != 0) e_err = 1;
      if (e_err) return;
      segsz = wide ? 128 : 32;
      gl = 32 >> sz;
      for (int g = 0; g < 32 / gl; g++) begin
         k0 = e_n;
         for (int l = g * gl; l < (g + 1) * gl; l++) begin
            if (act[l]) begin
               sb = a[l] & ~(segsz - 1);
               found = -1;
               for (int j = k0; j < e_n; j++) if (e_base[j] == sb) found = j;
               if (found < 0) begin
                  found = e_n;
                  e_base[e_n] = sb; e_bytes[e_n] = '0;
                  e_lanes[e_n] = '0; e_srv[e_n] = '0;
                  e_n++;
               end
               e_bytes[found] |= ((128'h1 << nb) - 1) << (a[l] - sb);
               winner = 1;
               if (st)
                  for (int m = 0; m < l; m++)
                     if (e_srv[found][m] && a[m] == a[l]) winner = 0;
               e_srv[found][l] = 1'b1;
               if (!st || winner) e_lanes[found][l] = 1'b1;
            end
         end
      end
   endtask

   task automatic run_warp(input string tag);
      int got, errs;
      bit stalled;
      logic [31:0] prev_base;
      model();
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
      for (int l = 0; l < 32; l++) req_addr[l*32 +: 32] = a[l];
      req_active = act; req_size = 2'(sz); req_wide = wide; req_store = st;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      got = 0; errs = 0; stalled = 0; prev_base = '0;
      for (int cyc = 0; cyc < 2000; cyc++) begin
         if (err_misalign) errs++;
         if (!txn_valid) break;
         if (stalled)
            chk(txn_base == prev_base, "R10", "base held over stall", txn_base, prev_base);
         txn_ready = ($urandom % 10) < 7;
         if (txn_ready) begin
            if (got < e_n) begin
               chk(txn_base == e_base[got], tag, "txn base", txn_base, e_base[got]);
               chk(txn_bytes == e_bytes[got], tag, "txn bytes", txn_bytes, e_bytes[got]);
               chk(txn_lanes == e_lanes[got], tag, "txn lanes", txn_lanes, e_lanes[got]);
            end
            got++;
         end
         stalled = !txn_ready;
         prev_base = txn_base;
         @(negedge clk);
      end
      txn_ready = 1'b0;
      chk(got == e_n, tag, "transaction count", got, e_n);
      chk(errs == (e_err ? 1 : 0), "R8", "error pulses", errs, e_err);
      chk(req_ready == 1'b1, "R9", "ready after completion", req_ready, 1);
      @(negedge clk);
      chk(err_misalign == 1'b0, "R8", "error one cycle only", err_misalign, 0);
   endtask

   task automatic set_linear(input logic [31:0] b, input int stride);
      for (int l = 0; l < 32; l++) a[l] = b + l * stride;
   endtask

   task automatic set_same(input logic [31:0] b);
      for (int l = 0; l < 32; l++) a[l] = b;
   endtask

   task automatic set_random();
      int nb;
      logic [31:0] region;
      sz = $urandom % 3; nb = 4 << sz;
      wide = $urandom % 2; st = $urandom % 2;
      act = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      region = 32'h0001_0000 + ($urandom % 64) * 128;
      if ($urandom % 2 == 1) set_linear(region, nb);
      else for (int l = 0; l < 32; l++) a[l] = region + ($urandom % 64) * nb;
      if ($urandom % 12 == 0) a[$urandom % 32] += 2;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
      chk(txn_valid == 1'b0, "R6", "no txn after reset", txn_valid, 0);
      chk(err_misalign == 1'b0, "R8", "no error after reset", err_misalign, 0);

      // R2: whole warp, 4 B, one 128 B line
      act = '1; sz = 0; wide = 1; st = 0; set_linear(32'h1000, 4); run_warp("R2");
      // R3: same pattern split into 32 B sectors
      wide = 0; run_warp("R3");
      // R1: one address, 8 B and 16 B: two and four groups
      sz = 1; wide = 1; set_same(32'h2040); run_warp("R1");
      sz = 2; run_warp("R1");
      // R1: linear 8 B and 16 B
      sz = 1; set_linear(32'h3000, 8); run_warp("R1");
      sz = 2; wide = 0; set_linear(32'h3000, 16); run_warp("R1");
      // R4: scattered inside one line, overlaps fold
      sz = 0; wide = 1;
      for (int l = 0; l < 32; l++) a[l] = 32'h4000 + ((l * 7) % 32) * 4;
      run_warp("R4");
      // R5: reversed addresses
      wide = 0; for (int l = 0; l < 32; l++) a[l] = 32'h5000 + (31 - l) * 4;
      run_warp("R5");
      // R6: no active lane; single active group
      act = '0; run_warp("R6");
      act = 32'h00FF_0000; sz = 2; set_linear(32'h6000, 16); run_warp("R6");
      // R7: store, all lanes on one word, lowest active lane wins
      act = 32'hFFFF_FFF8; sz = 0; wide = 1; st = 1; set_same(32'h7010); run_warp("R7");
      st = 0; run_warp("R7");
      // R8: misaligned lane and invalid size
      act = '1; sz = 1; st = 0; set_linear(32'h8000, 8); a[5] = a[5] + 4; run_warp("R8");
      sz = 3; set_linear(32'h8000, 16); run_warp("R8");
      // misaligned but inactive lane is not an error
      sz = 1; set_linear(32'h8000, 8); a[9] = a[9] + 4; act[9] = 1'b0; run_warp("R8");

      for (int n = 0; n < 80; n++) begin
         set_random();
         run_warp("R5");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule